// File: doc/BRIEF.md
# Start-Up Tuning-Word Predictor for a Digital Oscillator

This block shortens the wake-up of an all-digital phase-locked loop. It runs on the reference clock. Once per reference period it reads a counter of oscillator edges, which gives the oscillator frequency. On a wake request it first drives the largest tuning word. The edge count at that word acts as a temperature reading. From the change in that reading since the last start-up, it predicts a tuning word with a first-order model: the previous start-up word plus a coefficient times the change. It applies that word and measures the resulting count. It then hands the oscillator over to the loop filter.

When a sleep request arrives, the block adapts the model coefficient with one least-mean-squares step. The step uses the frequency error seen on the predicted word and the temperature change. Each later start-up therefore predicts better. The oscillator, the edge counter and the loop filter lie outside this block.

The edge count is a plain sample taken every reference period. Its producer is a free-running counter, so it has no valid/ready pair and there is no back-pressure. Wake and sleep requests are single-cycle control pulses.

Top module: `lms_otw_estimator`

## Requirements
- R1: Under reset, `tune_word` equals parameter WORD_INIT (default 32768), `loop_sel` is 1 and `est_done` is 0. The coefficient resets to W_INIT (default 256, which is 1.0 with 8 fractional bits). The stored previous word resets to WORD_INIT. The block starts with no stored count history.
- R2: A `wake_req` pulse while idle makes `loop_sel` 0 from the next cycle. `tune_word` is then 65535 for exactly two reference periods: a settle period and a measure period.
- R3: `osc_count` is sampled at the end of the measure period. The temperature change is that sample minus the sample stored at the previous start-up. On the first start-up after reset there is no stored sample, and the change is taken as 0. The new sample replaces the stored one.
- R4: The predicted word is the stored previous word plus floor(W × change / 256), clamped to the range 0..65535. It drives `tune_word` for two periods, starting in the third cycle after the wake request.
- R5: At the end of the second period on the predicted word, `osc_count` is sampled again and the error E = `freq_cmd` − count is kept. In the same cycle `loop_sel` returns to 1 and `est_done` pulses high for exactly one cycle.
- R6: A `sleep_req` after the handover sets W to W + floor(E × change × 256 / 2^MU_SHIFT), where MU_SHIFT defaults to 12. The result is clamped to the signed 16-bit range. The applied predicted word becomes the stored previous word.
- R7: A `sleep_req` at any earlier point of a start-up returns the block to idle (`loop_sel` 1) on the next cycle. W and the stored word are left unchanged. A `sleep_req` while idle has no effect.
- R8: A `wake_req` outside idle is ignored: no new start-up is run and no extra `est_done` appears.
- R9: While `loop_sel` stays high, `tune_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | One-cycle power-on request |
| sleep_req | input | 1 | One-cycle power-off request |
| osc_count | input | CNT_W (16) | Oscillator edges counted per reference period |
| freq_cmd | input | CNT_W (16) | Frequency command word (target count) |
| tune_word | output | OTW_W (16) | Tuning word offered to the oscillator |
| loop_sel | output | 1 | 0: this block drives the oscillator; 1: the loop filter does |
| est_done | output | 1 | One-cycle strobe at the handover after the predicted word was applied |

## Verification
A series of start-ups feeds temperature readings that rise, fall slightly, and then jump far in each direction. This separates a correctly signed, floor-rounded model from a truncating or sign-swapped one, and drives the clamp at both 65535 and 0. The counts measured on the predicted word give zero, positive and negative errors. The next start-up's prediction reveals whether the coefficient update has the right sign and scale. The sequence also includes an abort during settling, a sleep request while already idle, and a wake request during handover. Each of these must leave the following prediction exactly as the model expects.

// File: rtl/lmsest_pkg.sv
package lmsest_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HOT_SETTLE,
    PH_HOT_MEAS,
    PH_EST_SETTLE,
    PH_EST_MEAS,
    PH_HANDED
  } phase_e;
endpackage

// File: rtl/lmsest_seq.sv
module lmsest_seq
  import lmsest_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wake_req,
  input  logic   sleep_req,
  output phase_e phase
);
  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:       if (wake_req) phase_nx = PH_HOT_SETTLE;
      PH_HOT_SETTLE: phase_nx = sleep_req ? PH_IDLE : PH_HOT_MEAS;
      PH_HOT_MEAS:   phase_nx = sleep_req ? PH_IDLE : PH_EST_SETTLE;
      PH_EST_SETTLE: phase_nx = sleep_req ? PH_IDLE : PH_EST_MEAS;
      PH_EST_MEAS:   phase_nx = sleep_req ? PH_IDLE : PH_HANDED;
      PH_HANDED:     if (sleep_req) phase_nx = PH_IDLE;
      default:       phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/lmsest_predict.sv
module lmsest_predict #(
  parameter int OTW_W  = 16,
  parameter int CNT_W  = 16,
  parameter int W_W    = 16,
  parameter int W_FRAC = 8
) (
  input  logic signed [W_W-1:0]   coef,
  input  logic        [CNT_W-1:0] cnt_now,
  input  logic        [CNT_W-1:0] cnt_prev,
  input  logic        [OTW_W-1:0] word_prev,
  input  logic                    have_hist,
  output logic signed [CNT_W:0]   delta,
  output logic        [OTW_W-1:0] est
);
  localparam int PW = W_W + CNT_W + OTW_W + 2;
  localparam logic signed [PW-1:0] TOP = {{(PW-OTW_W){1'b0}}, {OTW_W{1'b1}}};

  logic signed [PW-1:0] prod, sum;

  always_comb begin
    delta = have_hist ? ($signed({1'b0, cnt_now}) - $signed({1'b0, cnt_prev})) : '0;
    prod  = PW'(coef) * PW'(delta);
    sum   = (prod >>> W_FRAC) + PW'($signed({1'b0, word_prev}));
    if (sum[PW-1])     est = '0;
    else if (sum > TOP) est = '1;
    else               est = sum[OTW_W-1:0];
  end
endmodule

// File: rtl/lmsest_adapt.sv
module lmsest_adapt #(
  parameter int CNT_W    = 16,
  parameter int W_W      = 16,
  parameter int W_FRAC   = 8,
  parameter int MU_SHIFT = 12
) (
  input  logic signed [W_W-1:0] coef,
  input  logic signed [CNT_W:0] err,
  input  logic signed [CNT_W:0] delta,
  output logic signed [W_W-1:0] coef_next
);
  localparam int AW = W_W + 2 * (CNT_W + 1) + W_FRAC + 1;
  localparam logic signed [AW-1:0] WMAX = {{(AW-W_W+1){1'b0}}, {(W_W-1){1'b1}}};
  localparam logic signed [AW-1:0] WMIN = {{(AW-W_W+1){1'b1}}, {(W_W-1){1'b0}}};

  logic signed [AW-1:0] step, acc;

  always_comb begin
    step = ((AW'(err) * AW'(delta)) <<< W_FRAC) >>> MU_SHIFT;
    acc  = AW'(coef) + step;
    if (acc > WMAX)      coef_next = WMAX[W_W-1:0];
    else if (acc < WMIN) coef_next = WMIN[W_W-1:0];
    else                 coef_next = acc[W_W-1:0];
  end
endmodule

// File: rtl/lms_otw_estimator.sv
module lms_otw_estimator
  import lmsest_pkg::*;
#(
  parameter int OTW_W     = 16,
  parameter int CNT_W     = 16,
  parameter int W_W       = 16,
  parameter int W_FRAC    = 8,
  parameter int MU_SHIFT  = 12,
  parameter int W_INIT    = 256,
  parameter int CNT_INIT  = 0,
  parameter int WORD_INIT = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_req,
  input  logic             sleep_req,
  input  logic [CNT_W-1:0] osc_count,
  input  logic [CNT_W-1:0] freq_cmd,
  output logic [OTW_W-1:0] tune_word,
  output logic             loop_sel,
  output logic             est_done
);
  phase_e phase;

  logic signed [W_W-1:0]   coef_q, coef_nx;
  logic        [CNT_W-1:0] cnt_prev_q;
  logic        [OTW_W-1:0] word_prev_q, est_q, est_c;
  logic                    hist_q, done_q;
  logic signed [CNT_W:0]   delta_q, delta_c, err_q;

  lmsest_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req), .phase(phase)
  );

  lmsest_predict #(.OTW_W(OTW_W), .CNT_W(CNT_W), .W_W(W_W), .W_FRAC(W_FRAC)) u_pred (
    .coef(coef_q), .cnt_now(osc_count), .cnt_prev(cnt_prev_q), .word_prev(word_prev_q),
    .have_hist(hist_q), .delta(delta_c), .est(est_c)
  );

  lmsest_adapt #(.CNT_W(CNT_W), .W_W(W_W), .W_FRAC(W_FRAC), .MU_SHIFT(MU_SHIFT)) u_adapt (
    .coef(coef_q), .err(err_q), .delta(delta_q), .coef_next(coef_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q      <= W_W'(W_INIT);
      cnt_prev_q  <= CNT_W'(CNT_INIT);
      word_prev_q <= OTW_W'(WORD_INIT);
      est_q       <= OTW_W'(WORD_INIT);
      hist_q      <= 1'b0;
      delta_q     <= '0;
      err_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= (phase == PH_EST_MEAS) && !sleep_req;
      if (phase == PH_HOT_MEAS && !sleep_req) begin
        cnt_prev_q <= osc_count;
        hist_q     <= 1'b1;
        est_q      <= est_c;
        delta_q    <= delta_c;
      end
      if (phase == PH_EST_MEAS && !sleep_req)
        err_q <= $signed({1'b0, freq_cmd}) - $signed({1'b0, osc_count});
      if (phase == PH_HANDED && sleep_req) begin
        coef_q      <= coef_nx;
        word_prev_q <= est_q;
      end
    end
  end

  assign tune_word = (phase == PH_HOT_SETTLE || phase == PH_HOT_MEAS) ? '1 : est_q;
  assign loop_sel  = (phase == PH_IDLE) || (phase == PH_HANDED);
  assign est_done  = done_q;
endmodule

// File: rtl/lmsest_checker.sv
module lmsest_checker #(
  parameter int OTW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic [OTW_W-1:0] tune_word,
  input logic             loop_sel,
  input logic             est_done
);
  AST_HOT_WORD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_sel) |-> tune_word == {OTW_W{1'b1}}); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |=> !est_done); // R5
  AST_DONE_AT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |-> (loop_sel && !$past(loop_sel))); // R5
  AST_SLEEP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> loop_sel); // R7
  AST_IDLE_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_sel && $past(loop_sel)) |-> $stable(tune_word)); // R9
endmodule

bind lms_otw_estimator lmsest_checker #(.OTW_W(OTW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .tune_word(tune_word),
  .loop_sel(loop_sel), .est_done(est_done)
);

// File: tb/tb_lms_otw_estimator.sv
module tb_lms_otw_estimator;
  localparam int CLK_NS = 10;
  localparam longint WORD0 = 32768;
  localparam longint COEF0 = 256;
  localparam int MU = 12;

  logic clk = 1'b0, rst_n = 1'b0, wake_req = 1'b0, sleep_req = 1'b0;
  logic [15:0] osc_count = '0, freq_cmd = 16'd120;
  logic [15:0] tune_word;
  logic loop_sel, est_done;

  lms_otw_estimator dut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .osc_count(osc_count), .freq_cmd(freq_cmd), .tune_word(tune_word),
    .loop_sel(loop_sel), .est_done(est_done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  longint m_w = COEF0, m_cprev = 0, m_word = WORD0, m_delta = 0, m_err = 0, m_est = WORD0;
  bit m_hist = 1'b0, m_locked = 1'b0;
  longint exp_q[$];

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the predicted word at every handover strobe
  always @(negedge clk) begin
    longint e;
    if (rst_n && est_done) begin
      if (exp_q.size() == 0) check("R8 unexpected est_done", 1, 0);
      else begin
        e = exp_q.pop_front();
        check("R4 predicted word at handover", tune_word, e);
        check("R5 loop_sel at est_done", loop_sel, 1);
      end
    end
  end

  task automatic power_up(longint hot, longint meas);
    @(negedge clk) wake_req = 1'b1;
    @(negedge clk) wake_req = 1'b0;
    check("R2 max word in settle", tune_word, 65535);
    check("R2 estimator owns oscillator", loop_sel, 0);
    osc_count = 16'(hot);
    @(negedge clk);
    check("R2 max word in measure", tune_word, 65535);
    m_delta = m_hist ? hot - m_cprev : 0;   // R3
    m_est = m_word + ((m_w * m_delta) >>> 8);
    if (m_est < 0) m_est = 0;
    if (m_est > 65535) m_est = 65535;
    m_cprev = hot;
    m_hist = 1'b1;
    exp_q.push_back(m_est);
    @(negedge clk);
    check("R4 predicted word applied", tune_word, m_est);
    check("R5 no early done", est_done, 0);
    osc_count = 16'(meas);
    @(negedge clk);
    check("R4 predicted word second period", tune_word, m_est);
    @(negedge clk);
    m_err = longint'(freq_cmd) - meas;
    m_locked = 1'b1;
    @(negedge clk);
    check("R5 done lasts one cycle", est_done, 0);
  endtask

  task automatic power_down();
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    check("R7 idle after sleep", loop_sel, 1);
    check("R9 word held while idle", tune_word, m_est);
    if (m_locked) begin   // R6
      m_w = m_w + ((m_err * m_delta * 256) >>> MU);
      if (m_w > 32767) m_w = 32767;
      if (m_w < -32768) m_w = -32768;
      m_word = m_est;
      m_locked = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", tune_word, WORD0);
    check("R1 reset loop_sel", loop_sel, 1);
    check("R1 reset done", est_done, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    power_up(1000, 110);  power_down();   // R3 first start-up: zero change
    power_up(1005, 110);  power_down();   // rising reading, positive error
    power_up(998, 120);                   // falling reading, floor rounding
    @(negedge clk) wake_req = 1'b1;       // R8 wake while handed over
    @(negedge clk) wake_req = 1'b0;
    check("R8 wake ignored loop_sel", loop_sel, 1);
    check("R8 wake ignored word", tune_word, m_est);
    repeat (6) @(negedge clk);
    check("R8 no new start-up", loop_sel, 1);
    power_down();
    @(negedge clk) sleep_req = 1'b1;      // R7 sleep while idle
    @(negedge clk) sleep_req = 1'b0;
    check("R7 idle sleep no effect", loop_sel, 1);
    @(negedge clk) wake_req = 1'b1;       // R7 abort during settle
    @(negedge clk) begin wake_req = 1'b0; sleep_req = 1'b1; end
    @(negedge clk) sleep_req = 1'b0;
    check("R7 abort returns idle", loop_sel, 1);
    check("R7 abort keeps word", tune_word, m_est);
    power_up(65000, 120); power_down();   // R4 clamp high
    power_up(0, 120);     power_down();   // R4 clamp low
    power_up(100, 100);   power_down();   // R6 positive error
    power_up(130, 140);   power_down();   // R6 negative error
    power_up(125, 120);   power_down();
    check("R5 all handovers seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule